// File: doc/BRIEF.md
# Shared-Bus External Register Writer

This block loads one of three external 8-bit latch registers that hang on a single shared 8-bit data bus. The three latches are a system control register, a monitor routing register and a clock and routing configuration register. Each has its own active-low select strobe. A client presents a target code and a data byte on a valid/ready handshake. The block then walks the bus through a fixed series of timed phases and keeps a shadow copy of every latch so the value can be read back without touching the bus.

A write runs through five phases, and each phase lasts `SETTLE_CYCLES` clock cycles:

- **SETUP**: the data lines are driven with the byte.
- **ENABLE**: the active-low output enable is pulled low.
- **STROBE_LO**: the selected strobe goes low.
- **STROBE_HI**: the strobe returns high. The shadow copy is updated on this edge.
- **RELEASE**: all data lines are driven high.

After RELEASE the machine returns to **IDLE**. In IDLE the data lines are released and the output enable is high. The transitions are:

- IDLE to SETUP when a write is launched.
- From each phase to the next when the settle timer expires.
- RELEASE to IDLE on the final expiry, which also raises a one-cycle done pulse.

When reset is released, the block runs a fixed power-on list before it accepts any client request:

1. System register = 0x08 (phantom supply disabled, codec still powered down).
2. System register = 0x88 (codec powered up).
3. Monitor register = 0x00.
4. Configuration register = 0x00.

Top module: `xreg_writer`

## Requirements
- R1: During reset and while idle, all three strobes are high, the output enable is high, the read/write line `bus_read` is low, `bus_drive` is low, `done` is low and all shadows are 0x00. `req_ready` is low during reset.
- R2: After reset the block performs exactly four writes in this order: system 0x08, then system 0x88, then monitor 0x00, then configuration 0x00. `req_ready` stays low until all four are complete. The phantom-disable bit is bit 3 and the codec power-up bit is bit 7.
- R3: `req_ready` is high only in IDLE after the power-on list has finished. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Target encoding: 0 = system, 1 = monitor, 2 = configuration.
- R4: Counting from the cycle after acceptance, each phase lasts exactly `SETTLE_CYCLES` cycles, in the order SETUP, ENABLE, STROBE_LO, STROBE_HI, RELEASE. `bus_oe_n` is high in SETUP and low from ENABLE through RELEASE.
- R5: `bus_drive` is high in all five phases and low in IDLE. `bus_data` carries the request byte in the first four phases and 0xFF in RELEASE.
- R6: Only the selected strobe goes low, only during STROBE_LO, and exactly once per write. The other two stay high.
- R7: The shadow of the target takes the byte at the edge where its strobe rises. The other shadows do not change.
- R8: `done` is high for exactly one cycle: the first IDLE cycle after RELEASE.
- R9: A request held with `req_valid` high while a write is in progress waits with `req_ready` low for the whole write. It is then accepted and performed, not dropped.
- R10: A request with target code 3 is accepted and ignored. No phase runs, no strobe falls, `done` stays low and no shadow changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_target | input | 2 | Target latch code (0 system, 1 monitor, 2 configuration, 3 ignored) |
| req_data | input | 8 | Byte to write |
| bus_data | output | 8 | Shared data bus output value |
| bus_drive | output | 1 | High while the data bus is driven |
| bus_oe_n | output | 1 | Active-low output enable for the latches |
| sel_sys_n | output | 1 | Active-low strobe for the system control latch |
| sel_mon_n | output | 1 | Active-low strobe for the monitor routing latch |
| sel_cfg_n | output | 1 | Active-low strobe for the configuration latch |
| bus_read | output | 1 | Read/write direction line, held low (write) |
| done | output | 1 | One-cycle pulse at the end of each write |
| shadow_sys | output | 8 | Shadow copy of the system control latch |
| shadow_mon | output | 8 | Shadow copy of the monitor routing latch |
| shadow_cfg | output | 8 | Shadow copy of the configuration latch |

## Verification
A wrong phase state shows up at once on the strobe, output-enable and drive pins, one cycle after it arises, because all of them are decoded directly from the state register. A wrong settle count shifts every later phase boundary, so it is caught at the first boundary the bench samples. A bad latched target or a bad shadow update appears on the shadow outputs at the edge where the strobe rises. An error in the power-on list order appears as a wrong sequence of strobe and data pairs before `req_ready` first rises.

// File: rtl/xw_pkg.sv
package xw_pkg;

    localparam int DATA_W      = 8;
    localparam int TGT_W       = 2;
    localparam int NUM_TARGETS = 3;
    localparam int BOOT_STEPS  = 4;
    localparam int BOOT_STEP_W = $clog2(BOOT_STEPS + 1);

    localparam logic [TGT_W-1:0] TGT_SYS  = 2'd0;
    localparam logic [TGT_W-1:0] TGT_MON  = 2'd1;
    localparam logic [TGT_W-1:0] TGT_CFG  = 2'd2;
    localparam logic [TGT_W-1:0] TGT_NONE = 2'd3;

    // bit positions decoded by the system latch's neighbours
    localparam int SYS_PHANTOM_OFF_BIT = 3;
    localparam int SYS_CODEC_ON_BIT    = 7;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ENABLE,
        PH_STROBE_LO,
        PH_STROBE_HI,
        PH_RELEASE
    } phase_t;

    typedef struct packed {
        logic [TGT_W-1:0]  tgt;
        logic [DATA_W-1:0] data;
    } wreq_t;

    function automatic wreq_t boot_entry(input logic [BOOT_STEP_W-1:0] step);
        wreq_t e;
        e.tgt  = TGT_SYS;
        e.data = '0;
        unique case (step)
            3'd0: begin
                e.tgt  = TGT_SYS;
                e.data[SYS_PHANTOM_OFF_BIT] = 1'b1;
            end
            3'd1: begin
                e.tgt  = TGT_SYS;
                e.data[SYS_PHANTOM_OFF_BIT] = 1'b1;
                e.data[SYS_CODEC_ON_BIT]    = 1'b1;
            end
            3'd2: e.tgt = TGT_MON;
            3'd3: e.tgt = TGT_CFG;
            default: e.tgt = TGT_NONE;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/xw_settle_timer.sv
module xw_settle_timer #(
    parameter int SETTLE_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expire
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(SETTLE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= RELOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == '0);

endmodule

// File: rtl/xw_boot_source.sv
module xw_boot_source
    import xw_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  advance,
    output logic  active,
    output wreq_t entry
);
    logic [BOOT_STEP_W-1:0] step_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (advance && active) begin
            step_q <= step_q + 1'b1;
        end
    end

    assign active = (step_q < BOOT_STEP_W'(BOOT_STEPS));
    assign entry  = boot_entry(step_q);

endmodule

// File: rtl/xw_sequencer.sv
module xw_sequencer
    import xw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [TGT_W-1:0]  req_target,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ready,
    input  logic              boot_active,
    input  wreq_t             boot_req,
    output logic              boot_advance,
    input  logic              expire,
    output logic              timer_load,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_drive,
    output logic              bus_oe_n,
    output logic [NUM_TARGETS-1:0] sel_n,
    output logic              commit,
    output logic [TGT_W-1:0]  commit_tgt,
    output logic [DATA_W-1:0] commit_data,
    output logic              done
);
    phase_t            state_q, state_d;
    logic [TGT_W-1:0]  tgt_q;
    logic [DATA_W-1:0] dat_q;
    logic              done_q;
    logic              launch_boot, launch_req;

    // next-state and transition decode
    always_comb begin
        state_d     = state_q;
        timer_load  = 1'b0;
        launch_boot = 1'b0;
        launch_req  = 1'b0;
        commit      = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                if (boot_active) begin
                    launch_boot = 1'b1;
                    timer_load  = 1'b1;
                    state_d     = PH_SETUP;
                end else if (req_valid && (req_target != TGT_NONE)) begin
                    launch_req = 1'b1;
                    timer_load = 1'b1;
                    state_d    = PH_SETUP;
                end
            end
            PH_SETUP: begin
                if (expire) begin
                    timer_load = 1'b1;
                    state_d    = PH_ENABLE;
                end
            end
            PH_ENABLE: begin
                if (expire) begin
                    timer_load = 1'b1;
                    state_d    = PH_STROBE_LO;
                end
            end
            PH_STROBE_LO: begin
                if (expire) begin
                    timer_load = 1'b1;
                    commit     = 1'b1;
                    state_d    = PH_STROBE_HI;
                end
            end
            PH_STROBE_HI: begin
                if (expire) begin
                    timer_load = 1'b1;
                    state_d    = PH_RELEASE;
                end
            end
            PH_RELEASE: begin
                if (expire) begin
                    state_d = PH_IDLE;
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // state register and write latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            tgt_q   <= TGT_NONE;
            dat_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == PH_RELEASE) && expire;
            if (launch_boot) begin
                tgt_q <= boot_req.tgt;
                dat_q <= boot_req.data;
            end else if (launch_req) begin
                tgt_q <= req_target;
                dat_q <= req_data;
            end
        end
    end

    // pin levels per phase
    always_comb begin
        bus_drive = 1'b1;
        bus_oe_n  = 1'b0;
        bus_data  = dat_q;
        sel_n     = '1;
        unique case (state_q)
            PH_IDLE: begin
                bus_drive = 1'b0;
                bus_oe_n  = 1'b1;
                bus_data  = '1;
            end
            PH_SETUP: begin
                bus_oe_n = 1'b1;
            end
            PH_ENABLE, PH_STROBE_HI: begin
            end
            PH_STROBE_LO: begin
                for (int i = 0; i < NUM_TARGETS; i++) begin
                    if (tgt_q == TGT_W'(i)) begin
                        sel_n[i] = 1'b0;
                    end
                end
            end
            PH_RELEASE: begin
                bus_data = '1;
            end
            default: begin
                bus_drive = 1'b0;
                bus_oe_n  = 1'b1;
            end
        endcase
    end

    assign req_ready    = (state_q == PH_IDLE) && !boot_active;
    assign boot_advance = launch_boot;
    assign commit_tgt   = tgt_q;
    assign commit_data  = dat_q;
    assign done         = done_q;

endmodule

// File: rtl/xw_shadow_bank.sv
module xw_shadow_bank
    import xw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [TGT_W-1:0]  tgt,
    input  logic [DATA_W-1:0] data,
    output logic [NUM_TARGETS-1:0][DATA_W-1:0] shadow
);
    for (genvar g = 0; g < NUM_TARGETS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow[g] <= '0;
            end else if (commit && (tgt == TGT_W'(g))) begin
                shadow[g] <= data;
            end
        end
    end

endmodule

// File: rtl/xreg_writer.sv
module xreg_writer
    import xw_pkg::*;
#(
    parameter int SETTLE_CYCLES = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [TGT_W-1:0]  req_target,
    input  logic [DATA_W-1:0] req_data,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_drive,
    output logic              bus_oe_n,
    output logic              sel_sys_n,
    output logic              sel_mon_n,
    output logic              sel_cfg_n,
    output logic              bus_read,
    output logic              done,
    output logic [DATA_W-1:0] shadow_sys,
    output logic [DATA_W-1:0] shadow_mon,
    output logic [DATA_W-1:0] shadow_cfg
);
    logic                  expire, timer_load;
    logic                  boot_active, boot_advance;
    wreq_t                 boot_req;
    logic                  commit;
    logic [TGT_W-1:0]      commit_tgt;
    logic [DATA_W-1:0]     commit_data;
    logic [NUM_TARGETS-1:0] sel_n;
    logic [NUM_TARGETS-1:0][DATA_W-1:0] shadow;

    xw_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (timer_load),
        .expire (expire)
    );

    xw_boot_source u_boot (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (boot_advance),
        .active  (boot_active),
        .entry   (boot_req)
    );

    xw_sequencer u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_target   (req_target),
        .req_data     (req_data),
        .req_ready    (req_ready),
        .boot_active  (boot_active),
        .boot_req     (boot_req),
        .boot_advance (boot_advance),
        .expire       (expire),
        .timer_load   (timer_load),
        .bus_data     (bus_data),
        .bus_drive    (bus_drive),
        .bus_oe_n     (bus_oe_n),
        .sel_n        (sel_n),
        .commit       (commit),
        .commit_tgt   (commit_tgt),
        .commit_data  (commit_data),
        .done         (done)
    );

    xw_shadow_bank u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .tgt    (commit_tgt),
        .data   (commit_data),
        .shadow (shadow)
    );

    assign sel_sys_n  = sel_n[0];
    assign sel_mon_n  = sel_n[1];
    assign sel_cfg_n  = sel_n[2];
    assign bus_read   = 1'b0;
    assign shadow_sys = shadow[0];
    assign shadow_mon = shadow[1];
    assign shadow_cfg = shadow[2];

endmodule

// File: rtl/xw_checker.sv
module xw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       done,
    input logic       bus_drive,
    input logic       bus_oe_n,
    input logic [7:0] bus_data,
    input logic       sel_sys_n,
    input logic       sel_mon_n,
    input logic       sel_cfg_n,
    input logic [7:0] shadow_sys,
    input logic [7:0] shadow_mon,
    input logic [7:0] shadow_cfg
);
    logic all_sel_high;
    assign all_sel_high = sel_sys_n & sel_mon_n & sel_cfg_n;

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sel_cfg_n, sel_mon_n, sel_sys_n}) >= 2); // R6

    AST_STROBE_UNDER_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !all_sel_high |-> (!bus_oe_n && bus_drive)); // R4

    AST_OE_LEADS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(all_sel_high) |-> $past(!bus_oe_n)); // R4

    AST_RELEASED_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_drive && bus_oe_n && all_sel_high)); // R5

    AST_HIGH_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe_n) |-> ($past(bus_data) == 8'hFF)); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_SYS_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(sel_sys_n) |-> $stable(shadow_sys)); // R7

    AST_MON_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(sel_mon_n) |-> $stable(shadow_mon)); // R7

    AST_CFG_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(sel_cfg_n) |-> $stable(shadow_cfg)); // R7

endmodule

bind xreg_writer xw_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .done       (done),
    .bus_drive  (bus_drive),
    .bus_oe_n   (bus_oe_n),
    .bus_data   (bus_data),
    .sel_sys_n  (sel_sys_n),
    .sel_mon_n  (sel_mon_n),
    .sel_cfg_n  (sel_cfg_n),
    .shadow_sys (shadow_sys),
    .shadow_mon (shadow_mon),
    .shadow_cfg (shadow_cfg)
);

// File: tb/xreg_writer_bench.sv
module xreg_writer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int S          = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid;
    logic       req_ready;
    logic [1:0] req_target;
    logic [7:0] req_data;
    logic [7:0] bus_data;
    logic       bus_drive, bus_oe_n, sel_sys_n, sel_mon_n, sel_cfg_n, bus_read, done;
    logic [7:0] shadow_sys, shadow_mon, shadow_cfg;

    int errors = 0;
    int checks = 0;
    int log_n  = 0;
    int log_t [64];
    int log_d [64];
    int exp_sh [3];
    logic [2:0] prev_sel;

    always #(CLK_PERIOD/2) clk = ~clk;

    xreg_writer #(.SETTLE_CYCLES(S)) u_xreg_writer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_target(req_target), .req_data(req_data), .bus_data(bus_data),
        .bus_drive(bus_drive), .bus_oe_n(bus_oe_n), .sel_sys_n(sel_sys_n),
        .sel_mon_n(sel_mon_n), .sel_cfg_n(sel_cfg_n), .bus_read(bus_read),
        .done(done), .shadow_sys(shadow_sys), .shadow_mon(shadow_mon),
        .shadow_cfg(shadow_cfg)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int sh(input int i);
        if (i == 0) return int'(shadow_sys);
        if (i == 1) return int'(shadow_mon);
        return int'(shadow_cfg);
    endfunction

    function automatic logic [2:0] sels();
        return {sel_cfg_n, sel_mon_n, sel_sys_n};
    endfunction

    // strobe monitor: record target and data at each falling strobe
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_sel <= 3'b111;
        end else begin
            for (int i = 0; i < 3; i++) begin
                if (prev_sel[i] && !sels()[i] && log_n < 64) begin
                    log_t[log_n] = i;
                    log_d[log_n] = int'(bus_data);
                    log_n++;
                end
            end
            prev_sel <= sels();
        end
    end

    task automatic check_idle(input string req);
        chk(sels() == 3'b111, req, "strobes idle", int'(sels()), 7);
        chk(bus_oe_n == 1'b1, req, "oe_n idle", int'(bus_oe_n), 1);
        chk(bus_drive == 1'b0 && bus_read == 1'b0, req, "drive/read idle",
            int'({bus_drive, bus_read}), 0);
    endtask

    task automatic check_shadows(input string req);
        for (int i = 0; i < 3; i++) begin
            chk(sh(i) == exp_sh[i], req, $sformatf("shadow %0d", i), sh(i), exp_sh[i]);
        end
    endtask

    // full write with a cycle-by-cycle pin check
    task automatic do_write(input int t, input int d);
        int n0;
        int old;
        n0 = log_n;
        old = exp_sh[t];
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_target = 2'(t); req_data = 8'(d);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 5 * S; k++) begin
            int p;
            logic [2:0] es;
            int ed;
            p  = k / S;
            es = (p == 2) ? ~(3'(3'b001 << t)) : 3'b111;
            ed = (p == 4) ? 8'hFF : d;
            chk(bus_oe_n == (p == 0), "R4", $sformatf("oe_n k=%0d", k),
                int'(bus_oe_n), int'(p == 0));
            chk(sels() == es, "R6", $sformatf("strobes k=%0d", k), int'(sels()), int'(es));
            chk(bus_drive && int'(bus_data) == ed, "R5", $sformatf("data k=%0d", k),
                int'({bus_drive, bus_data}), 256 + ed);
            chk(!req_ready && !done, "R3", $sformatf("ready/done busy k=%0d", k),
                int'({req_ready, done}), 0);
            exp_sh[t] = (k >= 3 * S) ? d : old;
            check_shadows("R7");
            @(negedge clk);
        end
        check_idle("R1");
        chk(done == 1'b1, "R8", "done at first idle cycle", int'(done), 1);
        chk(req_ready == 1'b1, "R3", "ready after write", int'(req_ready), 1);
        chk(log_n == n0 + 1, "R6", "one strobe per write", log_n - n0, 1);
        if (log_n == n0 + 1)
            chk(log_t[n0] == t && log_d[n0] == d, "R6", "strobed target/data",
                log_t[n0] * 256 + log_d[n0], t * 256 + d);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done one cycle wide", int'(done), 0);
    endtask

    function automatic int pat(input int j);
        case (j)
            0: return 8'h00;
            1: return 8'hFF;
            2: return 8'hA5;
            3: return 8'h5A;
            default: return 1 << (j - 4);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R3 watchdog expired: actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int w;
        int n0;
        rst_n = 1'b0; req_valid = 1'b0; req_target = 2'd0; req_data = 8'h00;
        for (int i = 0; i < 3; i++) exp_sh[i] = 0;
        repeat (3) @(negedge clk);
        check_idle("R1");
        chk(req_ready == 1'b0 && done == 1'b0, "R1", "ready/done in reset",
            int'({req_ready, done}), 0);
        check_shadows("R1");
        rst_n = 1'b1;

        // power-on list
        @(negedge clk);
        chk(req_ready == 1'b0, "R2", "not ready during boot", int'(req_ready), 0);
        while (!req_ready) @(negedge clk);
        chk(log_n == 4, "R2", "boot write count", log_n, 4);
        if (log_n == 4) begin
            chk(log_t[0] == 0 && log_d[0] == 8'h08, "R2", "boot 1", log_t[0]*256+log_d[0], 8'h08);
            chk(log_t[1] == 0 && log_d[1] == 8'h88, "R2", "boot 2", log_t[1]*256+log_d[1], 8'h88);
            chk(log_t[2] == 1 && log_d[2] == 8'h00, "R2", "boot 3", log_t[2]*256+log_d[2], 256);
            chk(log_t[3] == 2 && log_d[3] == 8'h00, "R2", "boot 4", log_t[3]*256+log_d[3], 512);
        end
        exp_sh[0] = 8'h88;
        check_shadows("R2");
        check_idle("R1");

        // sweep every target with every pattern
        for (int t = 0; t < 3; t++)
            for (int j = 0; j < 12; j++)
                do_write(t, pat(j));

        // ignored target code 3
        @(negedge clk);
        n0 = log_n;
        req_valid = 1'b1; req_target = 2'd3; req_data = 8'h77;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b1, "R10", "ready after ignored target", int'(req_ready), 1);
        for (int k = 0; k < 5 * S + 2; k++) begin
            chk(sels() == 3'b111 && !bus_drive && !done, "R10", "no activity",
                int'({sels(), bus_drive, done}), 8'b11100);
            @(negedge clk);
        end
        chk(log_n == n0, "R10", "no strobe logged", log_n, n0);
        check_shadows("R10");

        // request held while busy
        n0 = log_n;
        req_valid = 1'b1; req_target = 2'd0; req_data = 8'h3C;
        @(negedge clk);
        req_target = 2'd2; req_data = 8'hC3;
        w = 0;
        while (!req_ready) begin @(negedge clk); w++; end
        chk(w == 5 * S, "R9", "ready low for whole write", w, 5 * S);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (5 * S + 1) @(negedge clk);
        exp_sh[0] = 8'h3C; exp_sh[2] = 8'hC3;
        check_shadows("R9");
        chk(log_n == n0 + 2, "R9", "both writes strobed", log_n - n0, 2);
        if (log_n == n0 + 2)
            chk(log_t[n0] == 0 && log_t[n0+1] == 2 && log_d[n0+1] == 8'hC3, "R9",
                "held request order", log_t[n0+1] * 256 + log_d[n0+1], 2 * 256 + 8'hC3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule